// File: doc/BRIEF.md
# DRAM Address Multiplexer and Refresh Controller

This block sits between a host and a one-bit-wide dynamic memory of 1024 rows by 1024 columns. The host presents a 20-bit address, a direction bit and one bit of write data on a ready/valid handshake. The controller splits the address into a row half (upper ten bits) and a column half (lower ten bits). It sends the two halves one after the other over a single 10-line address bus. It strobes the row strobe for the first half and the column strobe for the second, drives the read/write and chip-enable lines, and returns read data to the host once the column strobe has been held for its access time.

A free-running interval timer raises a refresh request. The controller serves it as a row-only cycle: the row strobe falls with an internal 10-bit row counter steered onto the bus in place of the host row, the column strobe stays high, and the read/write line stays high so that the memory senses the row and writes it back. The counter advances after each refresh, so successive refreshes sweep all 1024 rows and then start again. A pending refresh wins over a waiting host request, but it never cuts into an access that is already running. The row-to-column delay, the column hold and the precharge gap are clock counts set by parameters.

Top module: `dram_mux_refresh`

## Requirements
- R1: After reset both strobes (`dramRasN`, `dramCasN`, active low) are high, `dramEn` is low, `rdValid` is low and `hostReady` is high.
- R2: For a host access the row half `hostAddr[19:10]` is on `dramAddr` when `dramRasN` falls, and the column half `hostAddr[9:0]` is on `dramAddr` when `dramCasN` falls. The column strobe is low only while the row strobe is low, and the address does not change while the column strobe is low.
- R3: `dramEn` is high in exactly those cycles in which `dramRasN` is low.
- R4: `dramRdWr` is 1 for reads and 0 for writes, held through the whole strobed part of a write, with the host write bit on `dramDin` when the column strobe falls.
- R5: A read returns `rdData` with a one-cycle `rdValid` pulse in the cycle after the column strobe rises. The value is the bit most recently written to that address, or 0 if the address was never written.
- R6: A refresh is a cycle in which the row strobe falls while the column strobe stays high throughout, with `dramRdWr` at 1 and the refresh row on `dramAddr`.
- R7: The refresh row is 0 for the first refresh after reset and rises by one per refresh, wrapping from 1023 to 0.
- R8: The column strobe falls only after the row strobe has been low for at least `RAS_CAS_CYC` cycles. It stays low for exactly `CAS_CYC` cycles. The row strobe stays high for at least `PRE_CYC` cycles between any two strobed cycles.
- R9: The timer requests a refresh every `REF_INTERVAL` cycles. A pending refresh is served before any waiting host request, so even under a host request that never drops, the gap between refreshes is at most `REF_INTERVAL + RAS_CAS_CYC + CAS_CYC + PRE_CYC + 1` cycles.
- R10: A request is taken in a cycle where `hostValid` and `hostReady` are both high. `hostReady` is low whenever the row strobe is low, so only one access is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host request present |
| hostReady | output | 1 | Controller can take a request this cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 20 | Host address, row half in the upper ten bits |
| hostWdata | input | 1 | Bit to write |
| rdValid | output | 1 | One-cycle pulse marking returned read data |
| rdData | output | 1 | Returned read bit |
| dramAddr | output | 10 | Shared row/column address bus |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramRdWr | output | 1 | 1 = read or refresh, 0 = write |
| dramEn | output | 1 | Chip enable |
| dramDin | output | 1 | Write data to the memory |
| dramDout | input | 1 | Read data from the memory |

## Verification
The bench goes after addresses at both ends of each half (all zeros, all ones, and equal row with differing column), because a design that swaps or shifts the halves would latch the wrong cell and read back stale data. It overwrites a 1 with a 0 and reads unwritten cells, which catches a write path stuck at one level or a read that returns the previous access's bit. It holds the host request high for a long stream, which exposes a design that lets host traffic starve refresh or slips a column strobe into a refresh. It also idles through more than 1024 refreshes to catch a row counter that skips, repeats or fails to wrap.

// File: rtl/dram_mux_refresh_pkg.sv
package dram_mux_refresh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_REF,
    ST_PRE
  } ctrlState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadReq;     // capture host request
    logic rasOn;       // row strobe asserted
    logic casOn;       // column strobe asserted
    logic hostCyc;     // strobed part of a host access
    logic selRefresh;  // route refresh row onto the bus
    logic selCol;      // route column half onto the bus
    logic captureRd;   // sample memory output
    logic incRefresh;  // advance refresh row
  } ctrlStrobe_t;

endpackage

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
  import dram_mux_refresh_pkg::*;
#(
  parameter int RAS_CAS_CYC  = 2,
  parameter int CAS_CYC      = 2,
  parameter int PRE_CYC      = 2,
  parameter int REF_CYC      = 4,
  parameter int REF_INTERVAL = 780
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostValid,
  output logic        hostReady,
  output ctrlStrobe_t strobe
);

  localparam int PH_A   = (RAS_CAS_CYC > CAS_CYC) ? RAS_CAS_CYC : CAS_CYC;
  localparam int PH_B   = (PRE_CYC > REF_CYC) ? PRE_CYC : REF_CYC;
  localparam int PH_MAX = (PH_A > PH_B) ? PH_A : PH_B;
  localparam int CNT_W  = $clog2(PH_MAX + 1);
  localparam int TMR_W  = $clog2(REF_INTERVAL + 1);

  localparam logic [CNT_W-1:0] ROW_LAST = CNT_W'(RAS_CAS_CYC - 1);
  localparam logic [CNT_W-1:0] COL_LAST = CNT_W'(CAS_CYC - 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] REF_LAST = CNT_W'(REF_CYC - 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(REF_INTERVAL - 1);

  ctrlState_t stateQ, stateD;
  logic [CNT_W-1:0] phaseQ;
  logic [TMR_W-1:0] timerQ;
  logic refPendQ;
  logic timerTick;
  logic takeRef;
  logic accept;
  logic phaseLast;

  // refresh interval timer
  assign timerTick = (timerQ == TMR_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (timerTick) begin
      timerQ <= '0;
    end else begin
      timerQ <= timerQ + 1'b1;
    end
  end

  assign takeRef   = (stateQ == ST_IDLE) && refPendQ;
  assign hostReady = (stateQ == ST_IDLE) && !refPendQ;
  assign accept    = hostReady && hostValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPendQ <= 1'b0;
    end else if (timerTick) begin
      refPendQ <= 1'b1;
    end else if (takeRef) begin
      refPendQ <= 1'b0;
    end
  end

  always_comb begin
    case (stateQ)
      ST_ROW:  phaseLast = (phaseQ == ROW_LAST);
      ST_COL:  phaseLast = (phaseQ == COL_LAST);
      ST_REF:  phaseLast = (phaseQ == REF_LAST);
      ST_PRE:  phaseLast = (phaseQ == PRE_LAST);
      default: phaseLast = 1'b0;
    endcase
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (takeRef) begin
          stateD = ST_REF;
        end else if (accept) begin
          stateD = ST_ROW;
        end
      end
      ST_ROW:  if (phaseLast) stateD = ST_COL;
      ST_COL:  if (phaseLast) stateD = ST_PRE;
      ST_REF:  if (phaseLast) stateD = ST_PRE;
      ST_PRE:  if (phaseLast) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      phaseQ <= '0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_IDLE || phaseLast) begin
        phaseQ <= '0;
      end else begin
        phaseQ <= phaseQ + 1'b1;
      end
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.loadReq    = accept;
    strobe.rasOn      = (stateQ == ST_ROW) || (stateQ == ST_COL) || (stateQ == ST_REF);
    strobe.casOn      = (stateQ == ST_COL);
    strobe.hostCyc    = (stateQ == ST_ROW) || (stateQ == ST_COL);
    strobe.selRefresh = (stateQ == ST_REF);
    strobe.selCol     = (stateQ == ST_COL);
    strobe.captureRd  = (stateQ == ST_COL) && phaseLast;
    strobe.incRefresh = (stateQ == ST_REF) && phaseLast;
  end

endmodule

// File: rtl/dram_mux_dpath.sv
module dram_mux_dpath
  import dram_mux_refresh_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int HOST_W = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              hostWrite,
  input  logic [HOST_W-1:0] hostAddr,
  input  logic              hostWdata,
  input  logic              dramDout,
  output logic [ADDR_W-1:0] dramAddr,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              dramRdWr,
  output logic              dramEn,
  output logic              dramDin,
  output logic              rdValid,
  output logic              rdData
);

  logic [ADDR_W-1:0] rowQ;
  logic [ADDR_W-1:0] colQ;
  logic [ADDR_W-1:0] refRowQ;
  logic [ADDR_W-1:0] rowSel;
  logic writeQ;
  logic wdataQ;
  logic rdValidQ;
  logic rdDataQ;

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ   <= '0;
      colQ   <= '0;
      writeQ <= 1'b0;
      wdataQ <= 1'b0;
    end else if (strobe.loadReq) begin
      rowQ   <= hostAddr[HOST_W-1:ADDR_W];
      colQ   <= hostAddr[ADDR_W-1:0];
      writeQ <= hostWrite;
      wdataQ <= hostWdata;
    end
  end

  // refresh row counter, wraps at the top row
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refRowQ <= '0;
    end else if (strobe.incRefresh) begin
      refRowQ <= refRowQ + 1'b1;
    end
  end

  // row source selector, then row/column multiplexing onto the bus
  assign rowSel   = strobe.selRefresh ? refRowQ : rowQ;
  assign dramAddr = strobe.selCol ? colQ : rowSel;

  assign dramRasN = !strobe.rasOn;
  assign dramCasN = !strobe.casOn;
  assign dramEn   = strobe.rasOn;
  assign dramRdWr = !(writeQ && strobe.hostCyc);
  assign dramDin  = wdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
      rdDataQ  <= 1'b0;
    end else begin
      rdValidQ <= strobe.captureRd && !writeQ;
      if (strobe.captureRd && !writeQ) begin
        rdDataQ <= dramDout;
      end
    end
  end

  assign rdValid = rdValidQ;
  assign rdData  = rdDataQ;

endmodule

// File: rtl/dram_mux_refresh.sv
module dram_mux_refresh
  import dram_mux_refresh_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int RAS_CAS_CYC  = 2,
  parameter int CAS_CYC      = 2,
  parameter int PRE_CYC      = 2,
  parameter int REF_INTERVAL = 780
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostValid,
  output logic                  hostReady,
  input  logic                  hostWrite,
  input  logic [2*ADDR_W-1:0]   hostAddr,
  input  logic                  hostWdata,
  output logic                  rdValid,
  output logic                  rdData,
  output logic [ADDR_W-1:0]     dramAddr,
  output logic                  dramRasN,
  output logic                  dramCasN,
  output logic                  dramRdWr,
  output logic                  dramEn,
  output logic                  dramDin,
  input  logic                  dramDout
);

  localparam int REF_CYC = RAS_CAS_CYC + CAS_CYC;

  ctrlStrobe_t strobe;

  dram_mux_ctrl #(
    .RAS_CAS_CYC (RAS_CAS_CYC),
    .CAS_CYC     (CAS_CYC),
    .PRE_CYC     (PRE_CYC),
    .REF_CYC     (REF_CYC),
    .REF_INTERVAL(REF_INTERVAL)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostValid(hostValid),
    .hostReady(hostReady),
    .strobe   (strobe)
  );

  dram_mux_dpath #(
    .ADDR_W(ADDR_W)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .hostWrite(hostWrite),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .dramDout (dramDout),
    .dramAddr (dramAddr),
    .dramRasN (dramRasN),
    .dramCasN (dramCasN),
    .dramRdWr (dramRdWr),
    .dramEn   (dramEn),
    .dramDin  (dramDin),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );

endmodule

// File: rtl/dram_mux_refresh_checker.sv
module dram_mux_refresh_checker #(
  parameter int ADDR_W      = 10,
  parameter int RAS_CAS_CYC = 2,
  parameter int PRE_CYC     = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] dramAddr,
  input logic              dramRasN,
  input logic              dramCasN
);

  logic [15:0] rasLowCnt;
  logic [15:0] rasHighCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasLowCnt  <= '0;
      rasHighCnt <= 16'(PRE_CYC);
    end else begin
      if (dramRasN) begin
        rasLowCnt <= '0;
        if (rasHighCnt != 16'hFFFF) rasHighCnt <= rasHighCnt + 1'b1;
      end else begin
        rasHighCnt <= '0;
        if (rasLowCnt != 16'hFFFF) rasLowCnt <= rasLowCnt + 1'b1;
      end
    end
  end

  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rstN)
    !dramCasN |-> !dramRasN); // R2

  AST_ADDR_HELD_CAS: assert property (@(posedge clk) disable iff (!rstN)
    (!dramCasN && !$past(dramCasN)) |-> $stable(dramAddr)); // R2

  AST_RDVALID_AFTER_CAS: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (dramCasN && !$past(dramCasN))); // R5

  AST_RAS_CAS_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramCasN) |-> (int'(rasLowCnt) >= RAS_CAS_CYC)); // R8

  AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |-> (int'(rasHighCnt) >= PRE_CYC)); // R8

  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> (dramRasN && dramCasN)); // R10

endmodule

bind dram_mux_refresh dram_mux_refresh_checker #(
  .ADDR_W     (ADDR_W),
  .RAS_CAS_CYC(RAS_CAS_CYC),
  .PRE_CYC    (PRE_CYC)
) uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .hostReady(hostReady),
  .rdValid  (rdValid),
  .dramAddr (dramAddr),
  .dramRasN (dramRasN),
  .dramCasN (dramCasN)
);

// File: tb/tb_dram_mux_refresh.sv
`timescale 1ns/1ps
module tb_dram_mux_refresh;

  localparam int AW  = 10;
  localparam int RC  = 2;
  localparam int CC  = 2;
  localparam int PC  = 2;
  localparam int RI  = 40;
  localparam int ROWS = 1 << AW;
  localparam int GAP_MAX = RI + RC + CC + PC + 1;
  localparam int WATCHDOG = 180000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostValid = 1'b0;
  logic hostReady;
  logic hostWrite = 1'b0;
  logic [2*AW-1:0] hostAddr = '0;
  logic hostWdata = 1'b0;
  logic rdValid;
  logic rdData;
  logic [AW-1:0] dramAddr;
  logic dramRasN;
  logic dramCasN;
  logic dramRdWr;
  logic dramEn;
  logic dramDin;
  logic dramDout = 1'b0;

  always #10 clk = ~clk;

  dram_mux_refresh #(
    .ADDR_W(AW), .RAS_CAS_CYC(RC), .CAS_CYC(CC), .PRE_CYC(PC), .REF_INTERVAL(RI)
  ) dut (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostReady(hostReady),
    .hostWrite(hostWrite), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .rdValid(rdValid), .rdData(rdData), .dramAddr(dramAddr),
    .dramRasN(dramRasN), .dramCasN(dramCasN), .dramRdWr(dramRdWr),
    .dramEn(dramEn), .dramDin(dramDin), .dramDout(dramDout)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference store and expectations
  bit refMem[int];
  bit dramMem[int];
  bit expRdQ[$];

  // monitor state
  int cycle = 0;
  bit prevRas = 1'b1;
  bit prevCas = 1'b1;
  bit haveTxn = 1'b0;
  bit txnWrite = 1'b0;
  int txnAddr = 0;
  bit txnData = 1'b0;
  bit inRefresh = 1'b0;
  int rasLowCnt = 0;
  int rasHighCnt = 100;
  int casLowCnt = 0;
  int expRef = 0;
  int refCount = 0;
  int wrapSeen = 0;
  int lastRefCycle = 0;
  int modelRow = 0;
  int modelCol = 0;

  always @(posedge clk) cycle <= cycle + 1;

  always @(negedge clk) begin
    if (rstN) begin
      // R3 enable tracks the row strobe
      chk(dramEn == !dramRasN, "R3", "enable vs row strobe", dramEn, !dramRasN);
      // R10 no new request while strobed
      if (!dramRasN) chk(!hostReady, "R10", "ready while strobed", hostReady, 0);
      // R2 column strobe only inside row strobe
      if (!dramCasN) chk(!dramRasN, "R2", "CAS outside RAS", dramRasN, 0);

      if (prevRas && !dramRasN) begin
        modelRow = int'(dramAddr);
        chk(rasHighCnt >= PC, "R8", "precharge cycles", rasHighCnt, PC);
        if (haveTxn) begin
          inRefresh = 1'b0;
          chk(int'(dramAddr) == (txnAddr >> AW), "R2", "row half", int'(dramAddr), txnAddr >> AW);
          chk(dramRdWr == !txnWrite, "R4", "rd/wr at row strobe", dramRdWr, !txnWrite);
        end else begin
          inRefresh = 1'b1;
          chk(int'(dramAddr) == expRef, "R7", "refresh row", int'(dramAddr), expRef);
          chk(dramRdWr == 1'b1, "R6", "refresh rd/wr level", dramRdWr, 1);
          if (refCount > 0)
            chk((cycle - lastRefCycle) <= GAP_MAX, "R9", "refresh gap", cycle - lastRefCycle, GAP_MAX);
          if (expRef == 0 && refCount > 0) begin
            wrapSeen++;
            chk(int'(dramAddr) == 0, "R7", "wrap to row 0", int'(dramAddr), 0);
          end
          expRef = (expRef + 1) % ROWS;
          refCount++;
          lastRefCycle = cycle;
        end
      end

      if (prevCas && !dramCasN) begin
        modelCol = int'(dramAddr);
        chk(!inRefresh, "R6", "CAS during refresh", inRefresh, 0);
        chk(haveTxn, "R2", "CAS without request", haveTxn, 1);
        chk(int'(dramAddr) == (txnAddr & (ROWS - 1)), "R2", "column half",
            int'(dramAddr), txnAddr & (ROWS - 1));
        chk(rasLowCnt >= RC, "R8", "row-to-column delay", rasLowCnt, RC);
        if (!dramRdWr) begin
          dramMem[modelRow * ROWS + modelCol] = dramDin;
        end else begin
          dramDout <= dramMem.exists(modelRow * ROWS + modelCol) ?
                      dramMem[modelRow * ROWS + modelCol] : 1'b0;
        end
        if (txnWrite) begin
          chk(dramDin == txnData, "R4", "write data", dramDin, txnData);
          chk(dramRdWr == 1'b0, "R4", "write level at CAS", dramRdWr, 0);
        end else begin
          chk(dramRdWr == 1'b1, "R4", "read level at CAS", dramRdWr, 1);
        end
      end

      if (!prevCas && dramCasN) begin
        chk(casLowCnt == CC, "R8", "column strobe width", casLowCnt, CC);
      end

      if (!prevRas && dramRasN) begin
        haveTxn = 1'b0;
        inRefresh = 1'b0;
      end

      if (rdValid) begin
        chk(!prevCas && dramCasN, "R5", "read return timing", prevCas, 0);
        if (expRdQ.size() == 0) begin
          chk(1'b0, "R5", "unexpected read data", rdData, 0);
        end else begin
          bit e;
          e = expRdQ.pop_front();
          chk(rdData == e, "R5", "read data", rdData, e);
        end
      end

      // request taken at the coming edge
      if (hostValid && hostReady) begin
        haveTxn = 1'b1;
        txnWrite = hostWrite;
        txnAddr = int'(hostAddr);
        txnData = hostWdata;
        if (hostWrite) begin
          refMem[int'(hostAddr)] = hostWdata;
        end else begin
          expRdQ.push_back(refMem.exists(int'(hostAddr)) ? refMem[int'(hostAddr)] : 1'b0);
        end
      end

      rasLowCnt  = dramRasN ? 0 : rasLowCnt + 1;
      rasHighCnt = dramRasN ? rasHighCnt + 1 : 0;
      casLowCnt  = dramCasN ? 0 : casLowCnt + 1;
      prevRas = dramRasN;
      prevCas = dramCasN;
    end
  end

  task automatic issue(input bit w, input int a, input bit d, input bit hold);
    @(posedge clk);
    #2;
    hostValid = 1'b1;
    hostWrite = w;
    hostAddr  = (2*AW)'(a);
    hostWdata = d;
    do @(negedge clk); while (!hostReady);
    if (!hold) begin
      @(posedge clk);
      #2;
      hostValid = 1'b0;
    end
  endtask

  task automatic drain();
    int n = 0;
    while ((expRdQ.size() != 0 || !dramRasN) && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cycle > WATCHDOG);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycle, WATCHDOG);
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dramRasN == 1'b1, "R1", "row strobe after reset", dramRasN, 1);
    chk(dramCasN == 1'b1, "R1", "column strobe after reset", dramCasN, 1);
    chk(dramEn == 1'b0, "R1", "enable after reset", dramEn, 0);
    chk(rdValid == 1'b0, "R1", "rdValid after reset", rdValid, 0);
    chk(hostReady == 1'b1, "R1", "ready after reset", hostReady, 1);

    // R2 R5 basic write then read
    issue(1'b1, 20'h37A5A, 1'b1, 1'b0);
    issue(1'b0, 20'h37A5A, 1'b0, 1'b0);
    // corners of both halves, unwritten cell
    issue(1'b1, 20'h00000, 1'b1, 1'b0);
    issue(1'b1, 20'hFFFFF, 1'b1, 1'b0);
    issue(1'b0, 20'h00000, 1'b0, 1'b0);
    issue(1'b0, 20'hFFFFF, 1'b0, 1'b0);
    issue(1'b0, 20'h00001, 1'b0, 1'b0);
    // R4 overwrite 1 with 0
    issue(1'b1, 20'h37A5A, 1'b0, 1'b0);
    issue(1'b0, 20'h37A5A, 1'b0, 1'b0);
    // same row, different columns; same column, different rows
    issue(1'b1, 20'h15003, 1'b1, 1'b0);
    issue(1'b1, 20'h15004, 1'b0, 1'b0);
    issue(1'b1, 20'h2B003, 1'b0, 1'b0);
    issue(1'b0, 20'h15003, 1'b0, 1'b0);
    issue(1'b0, 20'h15004, 1'b0, 1'b0);
    issue(1'b0, 20'h2B003, 1'b0, 1'b0);
    drain();

    // R9 continuous host traffic
    for (int i = 0; i < 300; i++) begin
      int a;
      a = (i * 7919 + 12345) % (1 << (2*AW));
      issue(i % 3 != 2, (i % 3 == 2) ? ((i - 2) * 7919 + 12345) % (1 << (2*AW)) : a,
            bit'((i >> 1) & 1), 1'b1);
    end
    @(posedge clk);
    #2 hostValid = 1'b0;
    drain();

    // R7 sweep past the top row
    while (refCount < ROWS + 8) @(negedge clk);
    chk(wrapSeen > 0, "R7", "wrap observed", wrapSeen, 1);
    chk(expRdQ.size() == 0, "R5", "reads outstanding", expRdQ.size(), 0);
    finishRun();
  end

endmodule